// File: doc/BRIEF.md
# Segment Register with Hidden Descriptor Cache

This block models a single segment register together with the descriptor copy kept behind it. A write to the register in real mode takes effect at once: the 16-bit value, shifted left by four, becomes the segment base and the segment is a fixed 64 KiB. A write in protected mode starts a fetch of the 8-byte descriptor from a descriptor table in memory. The fetch uses two 32-bit reads on a request/acknowledge read port. The table's base and byte limit come from a table register input. Base, limit, privilege level, granularity, size and long-code bits are decoded and held in a hidden cache.

Every later access turns an offset into a linear address using only the cached copy. The access is checked against the effective segment limit and against the privilege level, and a fault is raised instead of an address when a check fails. Code segments marked long bypass base and limit.

Top module: `seg_desc_unit`

## Requirements
- R1: A write with `pmode_i`=0 caches base = `sel_i`×16 and limit 0xFFFF, and `done_o` pulses on the next cycle. Any later access yields `lin_addr_o` = base + `off_i[15:0]` with `lin_vld_o`=1 and no fault.
- R2: A write with `pmode_i`=1 and a selector inside the table raises `mem_req_o`. The first read is at `tbl_base_i` + `sel_i[15:3]`×8 and the second at that address + 4. Each request is held with a stable address until `mem_ack_i`. `done_o` pulses one cycle after the second acknowledge.
- R3: If `sel_i[15:3]`×8+7 exceeds `tbl_limit_i`, `load_fault_o` pulses for one cycle on the next cycle. No memory read is made and the previous cache contents stay in use.
- R4: The fetched first word holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The second word holds base[23:16] in bits 7:0 and the access byte in bits 15:8. Within the access byte, bit 11 of the word marks a code segment and bits 14:13 are the privilege level. The second word also holds limit[19:16] in bits 19:16, L in bit 21, D in bit 22, G in bit 23 and base[31:24] in bits 31:24.
- R5: With G=0 an access whose offset exceeds the 20-bit limit sets `limit_fault_o` with `lin_vld_o`=0. Otherwise `lin_addr_o` = base + offset.
- R6: With G=1 the effective limit is limit×4096 + 0xFFF.
- R7: A protected access with requested level `sel[1:0]` numerically greater than the cached privilege level sets `priv_fault_o`, with `lin_vld_o`=0.
- R8: For a code segment with L=1, `lin_addr_o` equals the offset and no limit check is made. The L bit has no effect on a data segment.
- R9: No memory request is issued while no segment write is in progress; accesses never touch the table.
- R10: `big_o` shows the cached D bit, and is 0 in real mode.
- R11: Access results appear on the cycle after `acc_i` and last one cycle. After reset the cache is a real-mode segment at 0 and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pmode_i | input | 1 | 1 = protected mode for the next write |
| ld_i | input | 1 | Segment register write strobe |
| sel_i | input | 16 | Selector or real-mode segment value |
| tbl_base_i | input | 32 | Descriptor table base address |
| tbl_limit_i | input | 16 | Descriptor table last valid byte offset |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read address |
| mem_rdata_i | input | 32 | Read data |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| busy_o | output | 1 | Descriptor fetch in progress |
| done_o | output | 1 | Cache updated |
| load_fault_o | output | 1 | Selector outside table |
| acc_i | input | 1 | Access strobe |
| off_i | input | 32 | Access offset |
| lin_addr_o | output | 32 | Linear address |
| lin_vld_o | output | 1 | Linear address valid |
| limit_fault_o | output | 1 | Offset beyond segment limit |
| priv_fault_o | output | 1 | Privilege violation |
| big_o | output | 1 | Cached default size, 1 = 32-bit |

## Verification
The assertions take for granted that `mem_rdata_i` is valid whenever `mem_ack_i` is high. They also assume `ld_i` is not raised while `busy_o` is set, because such a write is dropped. The bench answers each read with an acknowledge in the same cycle, taken from a small word array. It issues writes only while the block is idle and waits for `done_o` or `load_fault_o` before any access.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int LW = 20;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [LW-1:0] limit;
    logic [1:0]    dpl;
    logic [1:0]    rpl;
    logic          lng;
    logic          big;
    logic          gran;
    logic          real_m;
  } seg_cache_t;

  function automatic seg_cache_t real_cache(input logic [SW-1:0] seg);
    seg_cache_t c;
    c        = '0;
    c.base   = {{(AW-SW-4){1'b0}}, seg, 4'b0000};
    c.limit  = {{(LW-16){1'b0}}, 16'hFFFF};
    c.real_m = 1'b1;
    return c;
  endfunction

  function automatic seg_cache_t decode(input logic [31:0] w0, input logic [31:0] w1,
                                        input logic [1:0] rpl);
    seg_cache_t c;
    c.base   = {w1[31:24], w1[7:0], w0[31:16]};
    c.limit  = {w1[19:16], w0[15:0]};
    c.dpl    = w1[14:13];
    c.rpl    = rpl;
    c.lng    = w1[21] & w1[11];
    c.big    = w1[22];
    c.gran   = w1[23];
    c.real_m = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/seg_load.sv
module seg_load
  import seg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pmode_i,
  input  logic          ld_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] tbl_base_i,
  input  logic [15:0]   tbl_limit_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_fault_o,
  output seg_cache_t    cache_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD0, S_RD1} st_t;
  st_t st_q;
  logic [SW-1:0] sel_q;
  logic [31:0]   w0_q;
  logic          out_of_tbl;

  assign out_of_tbl = {sel_i[15:3], 3'b111} > tbl_limit_i;
  assign busy_o     = st_q != S_IDLE;
  assign mem_req_o  = busy_o;
  assign mem_addr_o = tbl_base_i + {16'b0, sel_q[15:3], 3'b000}
                    + ((st_q == S_RD1) ? 32'd4 : 32'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      sel_q        <= '0;
      w0_q         <= '0;
      done_o       <= 1'b0;
      load_fault_o <= 1'b0;
      cache_o      <= real_cache('0);
    end else begin
      done_o       <= 1'b0;
      load_fault_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (ld_i) begin
          if (!pmode_i) begin
            cache_o <= real_cache(sel_i);
            done_o  <= 1'b1;
          end else if (out_of_tbl) begin
            load_fault_o <= 1'b1;
          end else begin
            sel_q <= sel_i;
            st_q  <= S_RD0;
          end
        end
        S_RD0: if (mem_ack_i) begin
          w0_q <= mem_rdata_i;
          st_q <= S_RD1;
        end
        S_RD1: if (mem_ack_i) begin
          cache_o <= decode(w0_q, mem_rdata_i, sel_q[1:0]);
          done_o  <= 1'b1;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  p_fault_noreq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fault_o |-> !mem_req_o && !done_o);
  p_fault_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fault_o |-> $stable(cache_o));
  p_no_lookup_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !ld_i |=> !mem_req_o);
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seg_cache_t    cache_i,
  input  logic          acc_i,
  input  logic [AW-1:0] off_i,
  output logic [AW-1:0] lin_addr_o,
  output logic          lin_vld_o,
  output logic          limit_fault_o,
  output logic          priv_fault_o
);
  logic [AW-1:0] eff_lim;
  logic          lim_bad, prv_bad;

  assign eff_lim = cache_i.gran ? {cache_i.limit, 12'hFFF}
                                : {{(AW-LW){1'b0}}, cache_i.limit};
  assign lim_bad = !cache_i.real_m && !cache_i.lng && (off_i > eff_lim);
  assign prv_bad = !cache_i.real_m && (cache_i.rpl > cache_i.dpl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_addr_o    <= '0;
      lin_vld_o     <= 1'b0;
      limit_fault_o <= 1'b0;
      priv_fault_o  <= 1'b0;
    end else begin
      lin_addr_o    <= '0;
      lin_vld_o     <= 1'b0;
      limit_fault_o <= 1'b0;
      priv_fault_o  <= 1'b0;
      if (acc_i) begin
        limit_fault_o <= lim_bad;
        priv_fault_o  <= prv_bad;
        if (!lim_bad && !prv_bad) begin
          lin_vld_o <= 1'b1;
          if (cache_i.real_m)   lin_addr_o <= cache_i.base + {16'b0, off_i[15:0]};
          else if (cache_i.lng) lin_addr_o <= off_i;
          else                  lin_addr_o <= cache_i.base + off_i;
        end
      end
    end
  end

  p_fault_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_fault_o || priv_fault_o) |-> !lin_vld_o);
  p_real_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_vld_o && $past(cache_i.real_m) |-> lin_addr_o[31:21] == 11'd0);
  p_one_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(acc_i) |-> !lin_vld_o && !limit_fault_o && !priv_fault_o);
endmodule

// File: rtl/seg_desc_unit.sv
module seg_desc_unit
  import seg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pmode_i,
  input  logic        ld_i,
  input  logic [15:0] sel_i,
  input  logic [31:0] tbl_base_i,
  input  logic [15:0] tbl_limit_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ack_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        load_fault_o,
  input  logic        acc_i,
  input  logic [31:0] off_i,
  output logic [31:0] lin_addr_o,
  output logic        lin_vld_o,
  output logic        limit_fault_o,
  output logic        priv_fault_o,
  output logic        big_o
);
  seg_cache_t cache;

  seg_load u_load (
    .clk_i, .rst_ni, .pmode_i, .ld_i, .sel_i, .tbl_base_i, .tbl_limit_i,
    .mem_req_o, .mem_addr_o, .mem_rdata_i, .mem_ack_i,
    .busy_o, .done_o, .load_fault_o, .cache_o(cache)
  );

  seg_check u_check (
    .clk_i, .rst_ni, .cache_i(cache), .acc_i, .off_i,
    .lin_addr_o, .lin_vld_o, .limit_fault_o, .priv_fault_o
  );

  assign big_o = cache.big;

  p_real_small_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(!pmode_i) |-> !big_o);
endmodule

// File: tb/sim_seg_desc_unit.sv
module sim_seg_desc_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pmode = 1'b0, ld = 1'b0, acc = 1'b0;
  logic [15:0] sel = '0, tlim = 16'h00FF;
  logic [31:0] tbase = 32'h0000_0100, off = '0;
  logic        req, ack, busy, done, lfault, vld, limf, prvf, big;
  logic [31:0] addr, rdata, lin;
  logic [31:0] mem [0:63];
  int checks = 0, errors = 0, req_cnt = 0;

  always #2 clk = ~clk;

  assign ack   = req;
  assign rdata = mem[addr[7:2]];

  always @(posedge clk) if (req) req_cnt <= req_cnt + 1;

  seg_desc_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .pmode_i(pmode), .ld_i(ld), .sel_i(sel),
    .tbl_base_i(tbase), .tbl_limit_i(tlim), .mem_req_o(req), .mem_addr_o(addr),
    .mem_rdata_i(rdata), .mem_ack_i(ack), .busy_o(busy), .done_o(done),
    .load_fault_o(lfault), .acc_i(acc), .off_i(off), .lin_addr_o(lin),
    .lin_vld_o(vld), .limit_fault_o(limf), .priv_fault_o(prvf), .big_o(big)
  );

  task automatic chk(input string req_s, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic set_desc(input int idx, input logic [31:0] b, input logic [19:0] l,
                          input logic [7:0] ab, input logic [3:0] fl);
    mem[idx*2]   = {b[15:0], l[15:0]};
    mem[idx*2+1] = {b[31:24], fl, l[19:16], ab, b[23:16]};
  endtask

  // returns {fault, done}
  task automatic load(input logic pm, input logic [15:0] s, output logic [1:0] res);
    @(negedge clk); pmode = pm; sel = s; ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    res = 2'b00;
    for (int i = 0; i < 10; i++) begin
      if (done || lfault) begin res = {lfault, done}; break; end
      @(negedge clk);
    end
  endtask

  // returns {vld, limf, prvf}, lin
  task automatic access(input logic [31:0] o, output logic [2:0] fl, output logic [31:0] a);
    @(negedge clk); off = o; acc = 1'b1;
    @(negedge clk); acc = 1'b0;
    fl = {vld, limf, prvf}; a = lin;
  endtask

  task automatic t_reset();
    logic [2:0] f; logic [31:0] a;
    chk("R11 reset pulses", {req, done, lfault, vld, limf, prvf, big}, 0);
    access(32'h0000_1234, f, a);
    chk("R11 reset real seg 0 flags", f, 3'b100);
    chk("R11 reset real seg 0 addr", a, 32'h1234);
    @(negedge clk);
    chk("R11 one-cycle result", vld, 0);
  endtask

  task automatic t_real();
    logic [1:0] r; logic [2:0] f; logic [31:0] a;
    load(1'b0, 16'hF000, r);
    chk("R1 real load done", r, 2'b01);
    access(32'h0000_FFFF, f, a);
    chk("R1 real addr F000:FFFF", {f, a}, {3'b100, 32'h000F_FFFF});
    load(1'b0, 16'hFFFF, r);
    access(32'hABCD_FFFF, f, a);
    chk("R1 real addr FFFF:FFFF upper offset ignored", {f, a}, {3'b100, 32'h0010_FFEF});
    chk("R10 real big", big, 0);
  endtask

  task automatic t_byte_limit();
    logic [1:0] r; logic [2:0] f; logic [31:0] a;
    int c0;
    set_desc(1, 32'h0010_0000, 20'h000FF, 8'h92, 4'h0);
    @(negedge clk); pmode = 1'b1; sel = 16'h0008; ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    chk("R2 first read addr", {req, addr}, {1'b1, 32'h0000_0108});
    @(negedge clk);
    chk("R2 second read addr", {req, addr}, {1'b1, 32'h0000_010C});
    @(negedge clk);
    chk("R2 done after second ack", {done, req}, 2'b10);
    access(32'h0000_00FF, f, a);
    chk("R4 R5 last byte in limit", {f, a}, {3'b100, 32'h0010_00FF});
    access(32'h0000_0100, f, a);
    chk("R5 one past limit", {f, a}, {3'b010, 32'h0});
    chk("R10 D=0", big, 0);
    c0 = req_cnt;
    access(32'h10, f, a); access(32'h20, f, a); access(32'h30, f, a);
    chk("R9 accesses issue no reads", req_cnt - c0, 0);
  endtask

  task automatic t_gran();
    logic [1:0] r; logic [2:0] f; logic [31:0] a;
    set_desc(2, 32'h1234_5678, 20'h00001, 8'h92, 4'hC);
    load(1'b1, 16'h0010, r);
    chk("R2 gran load done", r, 2'b01);
    access(32'h0000_1FFF, f, a);
    chk("R6 scaled limit top", {f, a}, {3'b100, 32'h1234_7677});
    access(32'h0000_2000, f, a);
    chk("R6 scaled limit exceeded", f, 3'b010);
    chk("R10 D=1", big, 1);
  endtask

  task automatic t_priv();
    logic [1:0] r; logic [2:0] f; logic [31:0] a;
    set_desc(3, 32'h0, 20'hFFFFF, 8'hB2, 4'h0);
    load(1'b1, 16'h001A, r);
    access(32'h40, f, a);
    chk("R7 rpl2 > dpl1 fault", f, 3'b001);
    load(1'b1, 16'h0019, r);
    access(32'h40, f, a);
    chk("R7 rpl1 == dpl1 ok", {f, a}, {3'b100, 32'h40});
  endtask

  task automatic t_long();
    logic [1:0] r; logic [2:0] f; logic [31:0] a;
    set_desc(4, 32'h5555_0000, 20'h00010, 8'h9A, 4'h2);
    load(1'b1, 16'h0020, r);
    access(32'h00FF_0000, f, a);
    chk("R8 long code base 0 no limit", {f, a}, {3'b100, 32'h00FF_0000});
    set_desc(5, 32'h5555_0000, 20'h00010, 8'h92, 4'h2);
    load(1'b1, 16'h0028, r);
    access(32'h20, f, a);
    chk("R8 L ignored on data", f, 3'b010);
    access(32'h10, f, a);
    chk("R8 data uses base", {f, a}, {3'b100, 32'h5555_0010});
  endtask

  task automatic t_tbl_fault();
    logic [1:0] r; logic [2:0] f; logic [31:0] a;
    int c0;
    set_desc(4, 32'h0000_8000, 20'h000FF, 8'h92, 4'h0);
    tlim = 16'h0027;
    load(1'b1, 16'h0020, r);
    chk("R3 entry at table end loads", r, 2'b01);
    c0 = req_cnt;
    load(1'b1, 16'h0028, r);
    chk("R3 entry past table faults", r, 2'b10);
    chk("R3 no read on fault", req_cnt - c0, 0);
    access(32'h5, f, a);
    chk("R3 old cache kept", {f, a}, {3'b100, 32'h0000_8005});
    tlim = 16'h00FF;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real();
    t_byte_limit();
    t_gran();
    t_priv();
    t_long();
    t_tbl_fault();
    repeat (2) @(negedge clk);
    report();
  end
endmodule